// File: doc/BRIEF.md
# Pin-Controlled Down-Counting Timer

This block is a down-counting timer whose counting is paced or controlled by one external input pin. A role field selects how the pin is used. It can be an event clock, where every falling edge is one count. It can be a level gate on the internal prescaled clock. It can also be a start trigger, in a one-shot form or a retriggerable form. A clock-source bit can instead give the internal prescaled clock sole control, and then the pin plays no part in counting. The pin passes through a synchronizer and an edge detector. Every falling edge raises a one-cycle interrupt pulse, whatever the role, the clock source or the enable.

Software sets up the block through four word-wide locations on a small register port: a role/control word, a write-only prescaler word, a reload value and a live count readback. A level count-enable input freezes or releases counting. A one-cycle terminal-count pulse marks the decrement from one. The counter then either parks at zero or reloads and continues. The interrupt output is a raw request, and masking belongs to the interrupt controller.

Top module: `tmr_pin_ctrl`

## Requirements
- R1: After reset the terminal-count and interrupt outputs are low, and reading locations 0, 2 and 3 returns zero.
- R2: Location 0 (role/control word) reads back bits 7:1 as written, and bit 0 always reads 0. Bits 5:4 are the pin role: 00 event clock, 01 gate, 10 one-shot trigger, 11 retriggerable trigger.
- R3: Location 1 (prescaler word) is write-only and reads as zero. Bits 7:2 are the divide D (1..63, with 0 meaning 64). Bit 1 is the clock source (1 internal, 0 pin role applies). Bit 0 selects modulo (1) or single-pass (0).
- R4: Location 2 holds the reload value and reads back. Location 3 returns the live count. Writing location 0 with bit 0 set copies the reload value into the counter and restarts the prescaler.
- R5: Each falling edge of the pin gives exactly one one-cycle interrupt pulse, for every role, clock source and enable state.
- R6: In event-clock role with the pin as source, each falling edge decrements the count by one.
- R7: On the internal clock, one decrement happens every D cycles. In modulo, terminal-count pulses repeat every N*D cycles for reload N.
- R8: In gate role the count advances only while the synchronized pin is high, and it holds while the pin is low.
- R9: In one-shot trigger role a load leaves the counter waiting. The first falling edge reloads and starts it, and later edges during the count are ignored. Terminal count arrives N*D cycles after the trigger's interrupt pulse.
- R10: In retriggerable role a falling edge during the count reloads and restarts it. Terminal count arrives N*D cycles after the last edge's interrupt pulse.
- R11: Terminal count is a one-cycle pulse on the decrement from 1. In single-pass the count then stays at 0, and in modulo it reloads.
- R12: With count-enable low the count and prescaler hold, and the interrupt pulses continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous external timer pin |
| cnt_en | input | 1 | Count enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register location |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Registered read data for reg_addr |
| tc_o | output | 1 | Terminal-count pulse |
| irq_o | output | 1 | Falling-edge interrupt pulse |

## Verification
The interrupt pulse and the terminal-count pulse can fall in the same cycle. In event-clock role, the falling edge that takes the count from one to zero drives both flops at the same edge. The bench loads N, feeds exactly N edges and requires the cycle stamps of the last interrupt and the last terminal count to be equal. A retrigger edge can also collide with a pending decrement; the reload must win, and that is judged by the terminal-count distance from the last interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ROLE_EVCLK     = 2'b00,
    ROLE_GATE      = 2'b01,
    ROLE_TRIG_ONCE = 2'b10,
    ROLE_TRIG_RE   = 2'b11
  } pin_role_e;

  localparam logic [1:0] LOC_CTRL  = 2'd0;
  localparam logic [1:0] LOC_PRESC = 2'd1;
  localparam logic [1:0] LOC_LOAD  = 2'd2;
  localparam logic [1:0] LOC_COUNT = 2'd3;

  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_ROLE_LO = 4;
  localparam int PRE_MOD_BIT  = 0;
  localparam int PRE_SRC_BIT  = 1;
  localparam int PRE_DIV_LO   = 2;
  localparam int PRE_DIV_W    = 6;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sr[STAGES-1];
  end

  assign lvl  = sr[STAGES-1];
  assign fall = prev & ~sr[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int LIM_W = DIV_W + 1;

  logic [DIV_W-1:0] cnt;
  logic [LIM_W-1:0] lim;

  always_comb begin
    if (div == '0) lim = LIM_W'(1) << DIV_W;
    else           lim = {1'b0, div};
  end

  assign tick = run && ({1'b0, cnt} == (lim - 1'b1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= '0;
    else if (run)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [1:0]           addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic [REG_W-1:0]     count,
  output logic [REG_W-1:0]     ctrl_q,
  output logic [PRE_DIV_W-1:0] div,
  output logic                 clk_int,
  output logic                 modulo,
  output logic [REG_W-1:0]     load_q,
  output logic                 load_go,
  output logic                 go_trig,
  output logic [REG_W-1:0]     rdata
);
  logic [REG_W-1:0] presc_q;

  assign load_go = we && (addr == LOC_CTRL) && wdata[CTRL_GO_BIT];
  // role written together with the go bit decides whether the start waits
  assign go_trig = wdata[CTRL_ROLE_LO+1] && !presc_q[PRE_SRC_BIT];

  assign div     = presc_q[PRE_DIV_LO +: PRE_DIV_W];
  assign clk_int = presc_q[PRE_SRC_BIT];
  assign modulo  = presc_q[PRE_MOD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      load_q  <= '0;
    end else if (we) begin
      case (addr)
        LOC_CTRL: begin
          ctrl_q              <= wdata;
          ctrl_q[CTRL_GO_BIT] <= 1'b0;
        end
        LOC_PRESC: presc_q <= wdata;
        LOC_LOAD:  load_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        LOC_CTRL:  rdata <= ctrl_q;
        LOC_LOAD:  rdata <= load_q;
        LOC_COUNT: rdata <= count;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  pin_role_e        role,
  input  logic             clk_int,
  input  logic             modulo,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_go,
  input  logic             go_trig,
  input  logic             pin_lvl,
  input  logic             pin_fall,
  input  logic             tick,
  output logic             pre_run,
  output logic             pre_clr,
  output logic             active,
  output logic [CNT_W-1:0] count,
  output logic             tc
);
  logic evclk, gate, trig, retrig, start, dec;

  assign evclk  = !clk_int && (role == ROLE_EVCLK);
  assign gate   = !clk_int && (role == ROLE_GATE);
  assign trig   = !clk_int && role[1];
  assign retrig = trig && role[0];

  assign start   = en && trig && pin_fall && (!active || retrig);
  assign pre_run = en && active && !evclk && !(gate && !pin_lvl);
  assign pre_clr = load_go || start;
  assign dec     = en && active && !start && (evclk ? pin_fall : tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      active <= 1'b0;
      tc     <= 1'b0;
    end else begin
      tc <= 1'b0;
      if (load_go) begin
        count  <= load_val;
        active <= !go_trig;
      end else if (start) begin
        count  <= load_val;
        active <= 1'b1;
      end else if (dec) begin
        if (count == CNT_W'(1)) begin
          tc <= 1'b1;
          if (modulo) count <= load_val;
          else begin
            count  <= '0;
            active <= 1'b0;
          end
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
  import tmr_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_in,
  input  logic             cnt_en,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             tc_o,
  output logic             irq_o
);
  logic                 pin_lvl, pin_fall;
  logic [REG_W-1:0]     ctrl_q, load_q, cnt_q;
  logic [PRE_DIV_W-1:0] div;
  logic                 clk_int, modulo, load_go, go_trig;
  logic                 pre_run, pre_clr, tick, active;
  pin_role_e            role;

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(pin_in), .lvl(pin_lvl), .fall(pin_fall)
  );

  tmr_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .count(cnt_q), .ctrl_q(ctrl_q), .div(div), .clk_int(clk_int),
    .modulo(modulo), .load_q(load_q), .load_go(load_go), .go_trig(go_trig),
    .rdata(reg_rdata)
  );

  assign role = pin_role_e'(ctrl_q[CTRL_ROLE_LO +: 2]);

  tmr_prescale #(.DIV_W(PRE_DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(pre_run), .clr(pre_clr), .div(div), .tick(tick)
  );

  tmr_core #(.CNT_W(REG_W)) u_core (
    .clk(clk), .rst(rst), .en(cnt_en), .role(role), .clk_int(clk_int),
    .modulo(modulo), .load_val(load_q), .load_go(load_go), .go_trig(go_trig),
    .pin_lvl(pin_lvl), .pin_fall(pin_fall), .tick(tick), .pre_run(pre_run),
    .pre_clr(pre_clr), .active(active), .count(cnt_q), .tc(tc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= pin_fall;
  end
endmodule

// File: rtl/tmr_pin_ctrl_chk.sv
module tmr_pin_ctrl_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             irq_o,
  input logic             tc_o,
  input logic [1:0]       reg_addr,
  input logic [REG_W-1:0] reg_rdata,
  input logic [REG_W-1:0] count,
  input logic [REG_W-1:0] load_val,
  input logic             load_go,
  input logic             pin_lvl,
  input logic             pin_fall,
  input logic [1:0]       role,
  input logic             clk_int,
  input logic             active
);
  AST_IRQ_FOLLOWS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!pin_lvl && $past(pin_lvl)) |=> irq_o); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R5
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !load_go) |=> $stable(count)); // R12
  AST_EDGE_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && active && !clk_int && role == 2'b00 && pin_fall && !load_go
     && count > REG_W'(1)) |=> count == $past(count) - 1'b1); // R6
  AST_TC_LANDING: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> (count == '0 || count == load_val)); // R11
  AST_PRESC_UNREADABLE: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd1) |=> reg_rdata == '0); // R3
endmodule

bind tmr_pin_ctrl tmr_pin_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .irq_o(irq_o), .tc_o(tc_o),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .count(cnt_q),
  .load_val(load_q), .load_go(load_go), .pin_lvl(pin_lvl),
  .pin_fall(pin_fall), .role(ctrl_q[5:4]), .clk_int(clk_int),
  .active(active)
);

// File: tb/tmr_pin_ctrl_test.sv
`timescale 1ns/1ps
module tmr_pin_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_in = 1'b1;
  logic       cnt_en = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       tc_o, irq_o;

  int checks = 0, fails = 0;
  int cyc = 0, irq_cnt = 0, tc_cnt = 0, last_irq = 0, last_tc = 0, prev_tc = 0;
  bit done = 0;

  tmr_pin_ctrl uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .cnt_en(cnt_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tc_o(tc_o), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (irq_o) begin irq_cnt = irq_cnt + 1; last_irq = cyc; end
    if (tc_o)  begin tc_cnt = tc_cnt + 1; prev_tc = last_tc; last_tc = cyc; end
  end

  function automatic logic [7:0] ctrl_b(input logic [1:0] role, input logic go);
    return {2'b00, role, 3'b000, go};
  endfunction
  function automatic logic [7:0] pre_b(input int d, input logic src, input logic m);
    return {6'(d), src, m};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int lo, input int hi);
    @(negedge clk); pin_in = 1'b0; idle(lo);
    pin_in = 1'b1; idle(hi);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      report();
    end
  end

  initial begin
    int v, n, k, d, i0, t0, s;
    s = $urandom(32'h5eed);
    idle(5); rst = 1'b0; idle(6);

    // R1: reset state
    check("R1 tc", int'(tc_o), 0);
    check("R1 irq", int'(irq_o), 0);
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd2, v); check("R1 load", v, 0);
    rd(2'd3, v); check("R1 count", v, 0);

    // R2: control word readback, go bit reads 0
    wr(2'd0, 8'hF6); rd(2'd0, v); check("R2 ctrl readback", v, 'hF6);
    wr(2'd0, 8'h2B); rd(2'd0, v); check("R2 go bit clear", v, 'h2A);

    // R3: prescaler is write-only
    wr(2'd1, 8'hA7); rd(2'd1, v); check("R3 presc reads zero", v, 0);

    // R4: reload value and load strobe (enable low)
    wr(2'd1, pre_b(1, 1'b1, 1'b0));
    wr(2'd2, 8'h5A); rd(2'd2, v); check("R4 load readback", v, 'h5A);
    wr(2'd0, ctrl_b(2'b00, 1'b1)); rd(2'd3, v); check("R4 count loaded", v, 'h5A);

    // R5/R12: every role with enable low, interrupts counted, count frozen
    for (int r = 0; r < 4; r++) begin
      wr(2'd1, pre_b(1, 1'b0, 1'b0));
      wr(2'd0, ctrl_b(2'(r), 1'b0));
      i0 = irq_cnt; n = 3 + ($urandom % 5);
      for (int p = 0; p < n; p++) pulse(3 + ($urandom % 4), 3 + ($urandom % 4));
      idle(4);
      check("R5 irq per falling edge", irq_cnt - i0, n);
      rd(2'd3, v); check("R12 count held while disabled", v, 'h5A);
    end

    // R6: event clock, random reload and edge count
    for (int t = 0; t < 6; t++) begin
      n = 5 + ($urandom % 36); k = 1 + ($urandom % (n - 1));
      cnt_en = 1'b0;
      wr(2'd1, pre_b($urandom % 64, 1'b0, 1'b0));
      wr(2'd2, 8'(n)); wr(2'd0, ctrl_b(2'b00, 1'b1));
      cnt_en = 1'b1;
      for (int p = 0; p < k; p++) pulse(3 + ($urandom % 3), 3 + ($urandom % 3));
      idle(4);
      rd(2'd3, v); check("R6 count after edges", v, n - k);
    end

    // R6/R11/R5: last edge gives terminal count in the same cycle as irq
    cnt_en = 1'b0; wr(2'd2, 8'd4); wr(2'd0, ctrl_b(2'b00, 1'b1)); cnt_en = 1'b1;
    t0 = tc_cnt;
    for (int p = 0; p < 4; p++) pulse(3, 4);
    idle(4);
    check("R11 one tc after N edges", tc_cnt - t0, 1);
    check("R5 irq and tc same cycle", last_tc, last_irq);
    rd(2'd3, v); check("R11 single-pass parks at zero", v, 0);

    // R7: internal modulo period N*D
    for (int t = 0; t < 5; t++) begin
      n = 2 + ($urandom % 11); d = 1 + ($urandom % 8);
      if (t == 4) begin n = 2; d = 0; end
      cnt_en = 1'b0;
      wr(2'd1, pre_b(d, 1'b1, 1'b1));
      wr(2'd2, 8'(n)); wr(2'd0, ctrl_b(2'($urandom % 4), 1'b1));
      t0 = tc_cnt; cnt_en = 1'b1;
      for (int w = 0; w < 2000 && tc_cnt - t0 < 3; w++) @(negedge clk);
      cnt_en = 1'b0;
      check("R7 modulo tc period", last_tc - prev_tc, n * ((d == 0) ? 64 : d));
    end

    // R11: single-pass internal, one tc then zero
    wr(2'd1, pre_b(2, 1'b1, 1'b0)); wr(2'd2, 8'd6); wr(2'd0, ctrl_b(2'b00, 1'b1));
    t0 = tc_cnt; cnt_en = 1'b1; idle(40);
    check("R11 single tc", tc_cnt - t0, 1);
    rd(2'd3, v); check("R11 count stays zero", v, 0);

    // R8: gate role
    cnt_en = 1'b0; @(negedge clk); pin_in = 1'b0; idle(5);
    wr(2'd1, pre_b(1, 1'b0, 1'b0)); wr(2'd2, 8'd50); wr(2'd0, ctrl_b(2'b01, 1'b1));
    cnt_en = 1'b1; idle(10);
    rd(2'd3, v); check("R8 hold while pin low", v, 50);
    @(negedge clk); pin_in = 1'b1; idle(17); pin_in = 1'b0; idle(6);
    rd(2'd3, v); check("R8 counts only while high", v, 33);
    cnt_en = 1'b0; @(negedge clk); pin_in = 1'b1; idle(5);

    // R9: one-shot trigger, second edge ignored
    wr(2'd1, pre_b(1, 1'b0, 1'b0)); wr(2'd2, 8'd30); wr(2'd0, ctrl_b(2'b10, 1'b1));
    cnt_en = 1'b1; idle(10);
    rd(2'd3, v); check("R9 waits for trigger", v, 30);
    t0 = tc_cnt; pulse(3, 3); i0 = last_irq;
    idle(4); pulse(3, 3);
    idle(40);
    check("R9 single tc", tc_cnt - t0, 1);
    check("R9 tc distance from first edge", last_tc - i0, 30);

    // R10: retriggerable, second edge restarts
    wr(2'd2, 8'd30); wr(2'd0, ctrl_b(2'b11, 1'b1)); idle(5);
    t0 = tc_cnt; pulse(3, 3); idle(8); pulse(3, 3); i0 = last_irq;
    idle(45);
    check("R10 single tc", tc_cnt - t0, 1);
    check("R10 tc distance from last edge", last_tc - i0, 30);
    cnt_en = 1'b0;

    done = 1;
    report();
  end
endmodule